// File: doc/BRIEF.md
# Data Address Generator with Modulo and Bit-Reversed Modes

This block is the integer address unit beside a signal-processing datapath. It keeps four register groups, each holding a current index, a signed step, a buffer start and a buffer size. When an access is requested on a group, the block emits a memory address derived from that group's current index. In the same clock edge, it moves the index forward by the step. Because wrap correction and bit reversal happen inside that one edge, ring buffers and FFT reordering take no extra cycles.

Three addressing styles are selected for each access. In linear mode the step is added with plain 16-bit rollover. In circular mode the result is folded back into the window that starts at the buffer start and spans the buffer size. In bit-reversed mode the address leaves with its low N bits mirrored, while the index itself advances linearly, which produces the scrambled order an in-place FFT needs. Registers are written through a small load port, one field at a time.

Top module: `addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every register of every group clears to 0, and after that edge `addr_vld`, `addr_out` and `idx_out` are 0.
- R2: An access (`acc_en` high, not cancelled by R9) sampled at an edge sets `addr_vld` to 1 after that edge and writes the updated index into the group's index register and into `idx_out`. In linear and circular modes `addr_out` equals the index value held before the access. When no access fires, `addr_vld` is 0 and `addr_out` and `idx_out` keep their values.
- R3: In linear mode the updated index is (index + step) mod 2^16, with the step taken as signed two's complement.
- R4: In circular mode, a sum index + step at or above start + size is reduced by size.
- R5: In circular mode, a sum index + step below start is raised by size. A sum inside [start, start + size) is kept unchanged.
- R6: In bit-reversed mode `addr_out` is the index with bits [N-1:0] mirrored (bit i takes bit N-1-i) and bits above N unchanged, where N = `brev_bits`. The index advances as in R3.
- R7: A `brev_bits` value above 16 acts as 16. A value of 0 or 1 leaves the address equal to the index.
- R8: `ld_sel` picks the field written by a load: 0 index, 1 step, 2 start, 3 size. A load sampled at one edge is seen by an access sampled at the next edge.
- R9: When a load and an access name the same group in one cycle, the load is performed and the access is dropped. `addr_vld` is 0 after that edge, `addr_out` and `idx_out` hold their values, and the step is not applied.
- R10: A load or access on one group leaves the registers of every other group unchanged. A load to one group does not block an access to another group in the same cycle.
- R11: `acc_mode` encoding: 0 linear, 1 circular, 2 bit-reversed, 3 linear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Register load strobe |
| ld_grp | input | 2 | Group written by the load |
| ld_sel | input | 2 | Field written: 0 index, 1 step, 2 start, 3 size |
| ld_data | input | 16 | Value loaded |
| acc_en | input | 1 | Access strobe |
| acc_grp | input | 2 | Group used by the access |
| acc_mode | input | 2 | 0 linear, 1 circular, 2 bit-reversed, 3 linear |
| brev_bits | input | 5 | Number of low bits mirrored in bit-reversed mode |
| addr_out | output | 16 | Address of the last access |
| addr_vld | output | 1 | High for one cycle after an access fires |
| idx_out | output | 16 | Updated index of the last access |

## Verification
Every result of this block is due exactly one rising edge after its stimulus. The address, the valid flag and the post-modified index are all registered at the edge where the access is sampled, and a load becomes visible to an access at the following edge. The bench drives inputs on the falling edge, lets one rising edge pass and reads the outputs on the next falling edge, so each check lands in the cycle where the value first appears. Dropped accesses and group isolation are observed through `addr_vld` and through later accesses that bring the stored index out on `idx_out` and `addr_out`.

// File: rtl/dag_pkg.sv
package dag_pkg;

    localparam int IDX_W   = 16;
    localparam int NUM_GRP = 4;
    localparam int GRP_W   = $clog2(NUM_GRP);
    localparam int BRW     = $clog2(IDX_W + 1);

    typedef enum logic [1:0] {
        MODE_LIN  = 2'd0,
        MODE_CIRC = 2'd1,
        MODE_BREV = 2'd2,
        MODE_LIN2 = 2'd3
    } dag_mode_e;

    typedef enum logic [1:0] {
        FLD_IDX  = 2'd0,
        FLD_STEP = 2'd1,
        FLD_BASE = 2'd2,
        FLD_SIZE = 2'd3
    } dag_fld_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] step;
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] size;
    } dag_grp_t;

endpackage

// File: rtl/dag_regfile.sv
module dag_regfile
    import dag_pkg::*;
#(
    parameter int N_GRP = NUM_GRP,
    parameter int G_W   = GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [G_W-1:0]   ld_grp,
    input  logic [1:0]       ld_sel,
    input  logic [IDX_W-1:0] ld_data,
    input  logic             wb_en,
    input  logic [G_W-1:0]   wb_grp,
    input  logic [IDX_W-1:0] wb_idx,
    input  logic [G_W-1:0]   rd_grp,
    output dag_grp_t         rd_q
);

    dag_grp_t grp_q [N_GRP];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < N_GRP; g++) begin
                grp_q[g] <= '0;
            end
        end else begin
            for (int g = 0; g < N_GRP; g++) begin
                if (ld_en && ld_grp == G_W'(g)) begin
                    case (dag_fld_e'(ld_sel))
                        FLD_IDX:  grp_q[g].idx  <= ld_data;
                        FLD_STEP: grp_q[g].step <= ld_data;
                        FLD_BASE: grp_q[g].base <= ld_data;
                        default:  grp_q[g].size <= ld_data;
                    endcase
                end else if (wb_en && wb_grp == G_W'(g)) begin
                    grp_q[g].idx <= wb_idx;
                end
            end
        end
    end

    assign rd_q = grp_q[rd_grp];

endmodule

// File: rtl/dag_modulo.sv
module dag_modulo
    import dag_pkg::*;
#(
    parameter int W = IDX_W
) (
    input  logic         circ,
    input  logic [W-1:0] idx,
    input  logic [W-1:0] step,
    input  logic [W-1:0] base,
    input  logic [W-1:0] size,
    output logic [W-1:0] nxt
);

    localparam int EXT_W = W + 2;

    logic signed [EXT_W-1:0] s_idx, s_step, s_base, s_size, s_sum, s_end, s_fold;

    always_comb begin
        s_idx  = $signed({2'b00, idx});
        s_step = $signed({{2{step[W-1]}}, step});
        s_base = $signed({2'b00, base});
        s_size = $signed({2'b00, size});
        s_sum  = s_idx + s_step;
        s_end  = s_base + s_size;
        if (s_sum >= s_end) begin
            s_fold = s_sum - s_size;
        end else if (s_sum < s_base) begin
            s_fold = s_sum + s_size;
        end else begin
            s_fold = s_sum;
        end
        nxt = circ ? s_fold[W-1:0] : s_sum[W-1:0];
    end

endmodule

// File: rtl/dag_bitrev.sv
module dag_bitrev
    import dag_pkg::*;
#(
    parameter int W   = IDX_W,
    parameter int N_W = BRW
) (
    input  logic [W-1:0]   src,
    input  logic [N_W-1:0] nbits,
    output logic [W-1:0]   dst
);

    logic [W-1:0]   cand [W+1];
    logic [N_W-1:0] n_eff;

    assign cand[0] = src;

    for (genvar k = 1; k <= W; k++) begin : g_width
        for (genvar i = 0; i < W; i++) begin : g_bit
            if (i < k) begin : g_mir
                assign cand[k][i] = src[k-1-i];
            end else begin : g_pass
                assign cand[k][i] = src[i];
            end
        end
    end

    always_comb begin
        n_eff = (nbits > N_W'(W)) ? N_W'(W) : nbits;
        dst   = cand[n_eff];
    end

endmodule

// File: rtl/addr_gen.sv
module addr_gen
    import dag_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_en,
    input  logic [GRP_W-1:0] ld_grp,
    input  logic [1:0]       ld_sel,
    input  logic [IDX_W-1:0] ld_data,
    input  logic             acc_en,
    input  logic [GRP_W-1:0] acc_grp,
    input  logic [1:0]       acc_mode,
    input  logic [BRW-1:0]   brev_bits,
    output logic [IDX_W-1:0] addr_out,
    output logic             addr_vld,
    output logic [IDX_W-1:0] idx_out
);

    dag_grp_t         rd_q;
    logic             fire;
    logic             is_circ;
    logic             is_brev;
    logic [IDX_W-1:0] nxt_idx;
    logic [IDX_W-1:0] rev_idx;
    logic [IDX_W-1:0] addr_d;

    assign fire    = acc_en && !(ld_en && ld_grp == acc_grp);
    assign is_circ = dag_mode_e'(acc_mode) == MODE_CIRC;
    assign is_brev = dag_mode_e'(acc_mode) == MODE_BREV;

    dag_regfile #(.N_GRP(NUM_GRP), .G_W(GRP_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_grp  (ld_grp),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .wb_en   (fire),
        .wb_grp  (acc_grp),
        .wb_idx  (nxt_idx),
        .rd_grp  (acc_grp),
        .rd_q    (rd_q)
    );

    dag_modulo #(.W(IDX_W)) u_mod (
        .circ (is_circ),
        .idx  (rd_q.idx),
        .step (rd_q.step),
        .base (rd_q.base),
        .size (rd_q.size),
        .nxt  (nxt_idx)
    );

    dag_bitrev #(.W(IDX_W), .N_W(BRW)) u_rev (
        .src   (rd_q.idx),
        .nbits (brev_bits),
        .dst   (rev_idx)
    );

    assign addr_d = is_brev ? rev_idx : rd_q.idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_out <= '0;
            addr_vld <= 1'b0;
            idx_out  <= '0;
        end else begin
            addr_vld <= fire;
            if (fire) begin
                addr_out <= addr_d;
                idx_out  <= nxt_idx;
            end
        end
    end

endmodule

// File: rtl/addr_gen_chk.sv
module addr_gen_chk
    import dag_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ld_en,
    input logic [GRP_W-1:0] ld_grp,
    input logic             acc_en,
    input logic [GRP_W-1:0] acc_grp,
    input logic [1:0]       acc_mode,
    input logic [IDX_W-1:0] cur_idx,
    input logic [IDX_W-1:0] cur_step,
    input logic [IDX_W-1:0] cur_base,
    input logic [IDX_W-1:0] cur_size,
    input logic [IDX_W-1:0] addr_out,
    input logic             addr_vld,
    input logic [IDX_W-1:0] idx_out
);

    logic              clash;
    logic              go;
    logic              lin;
    logic              in_win;
    logic              step_ok;
    logic [IDX_W+1:0]  lo_x, hi_x, idx_x, mag_x;

    assign clash   = acc_en && ld_en && (ld_grp == acc_grp);
    assign go      = acc_en && !clash;
    assign lin     = (acc_mode == 2'd0) || (acc_mode == 2'd3);
    assign lo_x    = {2'b00, cur_base};
    assign hi_x    = {2'b00, cur_base} + {2'b00, cur_size};
    assign idx_x   = {2'b00, cur_idx};
    assign mag_x   = cur_step[IDX_W-1] ? {2'b00, -cur_step} : {2'b00, cur_step};
    assign in_win  = (idx_x >= lo_x) && (idx_x < hi_x);
    assign step_ok = mag_x <= {2'b00, cur_size};

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!addr_vld && addr_out == '0 && idx_out == '0));

    // R2
    access_valid_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> addr_vld);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> (!addr_vld && $stable(addr_out) && $stable(idx_out)));

    // R9
    clash_drop_chk: assert property (@(posedge clk) disable iff (rst)
        clash |=> (!addr_vld && $stable(idx_out)));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (go && lin) |=> (addr_out == $past(cur_idx) &&
                         idx_out == $past(cur_idx + cur_step)));

    // R4
    circ_window_chk: assert property (@(posedge clk) disable iff (rst)
        (go && acc_mode == 2'd1 && in_win && step_ok) |=>
            ({2'b00, idx_out} >= $past(lo_x) && {2'b00, idx_out} < $past(hi_x)));

endmodule

bind addr_gen addr_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_grp   (ld_grp),
    .acc_en   (acc_en),
    .acc_grp  (acc_grp),
    .acc_mode (acc_mode),
    .cur_idx  (rd_q.idx),
    .cur_step (rd_q.step),
    .cur_base (rd_q.base),
    .cur_size (rd_q.size),
    .addr_out (addr_out),
    .addr_vld (addr_vld),
    .idx_out  (idx_out)
);

// File: tb/test_addr_gen.sv
module test_addr_gen;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [1:0]  ld_grp;
    logic [1:0]  ld_sel;
    logic [15:0] ld_data;
    logic        acc_en;
    logic [1:0]  acc_grp;
    logic [1:0]  acc_mode;
    logic [4:0]  brev_bits;
    logic [15:0] addr_out;
    logic        addr_vld;
    logic [15:0] idx_out;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    addr_gen i_addr_gen (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_grp    (ld_grp),
        .ld_sel    (ld_sel),
        .ld_data   (ld_data),
        .acc_en    (acc_en),
        .acc_grp   (acc_grp),
        .acc_mode  (acc_mode),
        .brev_bits (brev_bits),
        .addr_out  (addr_out),
        .addr_vld  (addr_vld),
        .idx_out   (idx_out)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [1:0] g, input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_grp = g; ld_sel = sel; ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic setup(input logic [1:0] g, input logic [15:0] idx, input logic [15:0] stp,
                         input logic [15:0] bs, input logic [15:0] sz);
        load(g, 2'd0, idx);
        load(g, 2'd1, stp);
        load(g, 2'd2, bs);
        load(g, 2'd3, sz);
    endtask

    task automatic access(input logic [1:0] g, input logic [1:0] md, input logic [4:0] nb);
        @(negedge clk);
        acc_en = 1'b1; acc_grp = g; acc_mode = md; brev_bits = nb;
        @(negedge clk);
        acc_en = 1'b0;
    endtask

    task automatic acc_chk(input string req, input logic [1:0] g, input logic [1:0] md,
                           input logic [4:0] nb, input logic [15:0] ea, input logic [15:0] ei);
        access(g, md, nb);
        chk({req, " vld"}, {15'd0, addr_vld}, 16'd1);
        chk({req, " addr"}, addr_out, ea);
        chk({req, " idx"}, idx_out, ei);
    endtask

    task automatic t_reset();
        chk("R1 vld", {15'd0, addr_vld}, 16'd0);
        chk("R1 addr", addr_out, 16'd0);
        chk("R1 idx", idx_out, 16'd0);
        // group registers clear: an access on group 3 shows index 0 and step 0
        acc_chk("R1 regs", 2'd3, 2'd0, 5'd0, 16'h0000, 16'h0000);
    endtask

    task automatic t_linear();
        setup(2'd0, 16'd100, 16'd3, 16'd0, 16'd0);
        acc_chk("R2 R3 lin", 2'd0, 2'd0, 5'd0, 16'd100, 16'd103);
        acc_chk("R3 lin2", 2'd0, 2'd0, 5'd0, 16'd103, 16'd106);
        load(2'd0, 2'd1, 16'hFFFB);
        acc_chk("R3 neg", 2'd0, 2'd0, 5'd0, 16'd106, 16'd101);
        load(2'd0, 2'd0, 16'hFFFE);
        load(2'd0, 2'd1, 16'd3);
        acc_chk("R3 roll", 2'd0, 2'd0, 5'd0, 16'hFFFE, 16'h0001);
        acc_chk("R11 mode3", 2'd0, 2'd3, 5'd0, 16'h0001, 16'h0004);
        // R2: idle cycle holds outputs and drops valid
        @(negedge clk);
        chk("R2 idle vld", {15'd0, addr_vld}, 16'd0);
        chk("R2 idle addr", addr_out, 16'h0001);
        chk("R2 idle idx", idx_out, 16'h0004);
    endtask

    task automatic t_circular();
        setup(2'd1, 16'd205, 16'd2, 16'd200, 16'd8);
        acc_chk("R5 inside", 2'd1, 2'd1, 5'd0, 16'd205, 16'd207);
        acc_chk("R4 wrap", 2'd1, 2'd1, 5'd0, 16'd207, 16'd201);
        load(2'd1, 2'd1, 16'hFFFD);
        acc_chk("R5 under", 2'd1, 2'd1, 5'd0, 16'd201, 16'd206);
        load(2'd1, 2'd1, 16'd8);
        acc_chk("R4 full", 2'd1, 2'd1, 5'd0, 16'd206, 16'd206);
        load(2'd1, 2'd1, 16'd1);
        acc_chk("R4 edge", 2'd1, 2'd1, 5'd0, 16'd206, 16'd207);
        acc_chk("R4 edge2", 2'd1, 2'd1, 5'd0, 16'd207, 16'd200);
    endtask

    task automatic t_bitrev();
        setup(2'd2, 16'h1231, 16'd1, 16'd0, 16'd0);
        acc_chk("R6 nib", 2'd2, 2'd2, 5'd4, 16'h1238, 16'h1232);
        load(2'd2, 2'd0, 16'h0001);
        acc_chk("R6 full", 2'd2, 2'd2, 5'd16, 16'h8000, 16'h0002);
        load(2'd2, 2'd0, 16'h0001);
        acc_chk("R7 sat", 2'd2, 2'd2, 5'd31, 16'h8000, 16'h0002);
        acc_chk("R7 one", 2'd2, 2'd2, 5'd1, 16'h0002, 16'h0003);
        acc_chk("R7 zero", 2'd2, 2'd2, 5'd0, 16'h0003, 16'h0004);
        // 8-point FFT reorder: 0 4 2 6 1 5 3 7
        load(2'd2, 2'd0, 16'h0000);
        for (int k = 0; k < 8; k++) begin
            logic [15:0] e;
            e = {13'd0, k[0], k[1], k[2]};
            acc_chk("R6 fft", 2'd2, 2'd2, 5'd3, e, 16'(k + 1));
        end
    endtask

    task automatic t_load_clash();
        setup(2'd3, 16'd50, 16'd5, 16'd0, 16'd0);
        // R8: load then access on the very next edge
        @(negedge clk);
        ld_en = 1'b1; ld_grp = 2'd3; ld_sel = 2'd0; ld_data = 16'd70;
        @(negedge clk);
        ld_en = 1'b0;
        acc_en = 1'b1; acc_grp = 2'd3; acc_mode = 2'd0; brev_bits = 5'd0;
        @(negedge clk);
        acc_en = 1'b0;
        chk("R8 next addr", addr_out, 16'd70);
        chk("R8 next idx", idx_out, 16'd75);
        // R9: same-group clash, load wins
        @(negedge clk);
        ld_en = 1'b1; ld_grp = 2'd3; ld_sel = 2'd0; ld_data = 16'd90;
        acc_en = 1'b1; acc_grp = 2'd3; acc_mode = 2'd0;
        @(negedge clk);
        ld_en = 1'b0; acc_en = 1'b0;
        chk("R9 vld", {15'd0, addr_vld}, 16'd0);
        chk("R9 addr hold", addr_out, 16'd70);
        chk("R9 idx hold", idx_out, 16'd75);
        acc_chk("R9 loaded", 2'd3, 2'd0, 5'd0, 16'd90, 16'd95);
        // R10: load to another group does not block the access
        @(negedge clk);
        ld_en = 1'b1; ld_grp = 2'd0; ld_sel = 2'd0; ld_data = 16'd500;
        acc_en = 1'b1; acc_grp = 2'd3; acc_mode = 2'd0;
        @(negedge clk);
        ld_en = 1'b0; acc_en = 1'b0;
        chk("R10 vld", {15'd0, addr_vld}, 16'd1);
        chk("R10 addr", addr_out, 16'd95);
        // R10: other groups kept their state
        acc_chk("R10 g1", 2'd1, 2'd1, 5'd0, 16'd200, 16'd201);
        acc_chk("R10 g2", 2'd2, 2'd0, 5'd0, 16'd8, 16'd9);
        acc_chk("R10 g0", 2'd0, 2'd0, 5'd0, 16'd500, 16'd503);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_grp = '0; ld_sel = '0; ld_data = '0;
        acc_en = 1'b0; acc_grp = '0; acc_mode = '0; brev_bits = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_linear();
        t_circular();
        t_bitrev();
        t_load_clash();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule